// File: doc/BRIEF.md
# Serial Link Receive Core with Comma Framing

This block is the digital heart of a 10-bit serial link. On the transmit side it takes one already-encoded 10-bit code group every ten bit times and shifts it out one bit per bit-clock cycle, least significant bit first. On the receive side it shifts the incoming serial stream into a 10-bit window and cuts it into code groups. The stream can be the line input or, for self-test, the block's own transmit stream. The block neither encodes nor decodes; the code groups pass through unchanged.

Word boundaries on the receive side come from one of three sources. A free-running count cuts a group every ten bits. A 7-bit comma found at the low end of the window, when framing is enabled, restarts that count so that the comma group comes out whole. A lock input, active low, ties the boundary to the transmit word phase. Each received group is held for a whole word time together with a flag that marks comma groups. Two complementary byte clocks run at half the word rate, so a downstream device can take successive groups on the rising edge of each clock in turn. The recovered bit clock is modelled as an ideal clock input; all logic runs on it.

Top module: `serdes_rx_core`

## Requirements
- R1: `tx_take` is high for one cycle in every ten. At the clock edge that ends a cycle with `tx_take` high, `tx_word` is sampled. Its bit 0 appears on `tx_serial` in the next cycle and bits 1 to 9 follow in the nine cycles after that.
- R2: Each cycle the receive path takes `tx_serial` as its input bit when `loop_en` is high and `rx_serial` when it is low.
- R3: Without a comma or lock event, a group is captured every ten bit times from the last ten received bits. The earliest of those bits goes to bit 0, and `rx_word` then holds the group until the next capture.
- R4: With `align_en` high and `lock_n` high, the window is checked on every cycle. When window bits 6:0, in bit-0-first order, read 0011111 (value 7'b1111100) or 1100000 (value 7'b0000011), the window is captured at once and the ten-bit count starts again.
- R5: `rx_sync` is high for the whole time a group captured on a comma match is shown, and low for every other group.
- R6: While `align_en` is low, comma patterns cause no capture and no `rx_sync`, and the current ten-bit count carries on.
- R7: While `lock_n` is low, groups are captured only at the edge one cycle after the transmit load edge, which places transmit words intact on `rx_word` in loopback. Commas are ignored and `rx_sync` stays low. When a boundary has been missed for more than ten bits, the count holds at ten and a capture follows at the first edge after `lock_n` is released.
- R8: `byte_clk_b` is always the complement of `byte_clk_a`. At the edge five bit times after a capture, if that edge is not itself a capture, `byte_clk_a` takes the parity of the number of groups captured so far. Neither clock changes at a capture edge.
- R9: While `rst_n` is low, `tx_serial`, `rx_word`, `rx_sync` and `byte_clk_a` are 0, `byte_clk_b` is 1 and `tx_take` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_word | input | 10 | Encoded code group to send |
| tx_take | output | 1 | High in the cycle whose closing edge samples `tx_word` |
| tx_serial | output | 1 | Serial transmit bit |
| rx_serial | input | 1 | Serial line input bit |
| loop_en | input | 1 | Selects the transmit stream as receive input |
| align_en | input | 1 | Enables comma framing |
| lock_n | input | 1 | Active low; ties receive boundaries to the transmit phase |
| rx_word | output | 10 | Received code group |
| rx_sync | output | 1 | Marks a group captured on a comma |
| byte_clk_a | output | 1 | Half-rate byte clock |
| byte_clk_b | output | 1 | Complement of `byte_clk_a` |

## Verification
The assertions assume that `align_en`, `lock_n` and `loop_en` change only between clock edges and are known on every edge after reset. They also assume that the flag and clock relations are judged only at the edges where a group is taken or a byte clock rises, never in the middle of a hold. The stimulus drives all inputs on the falling clock edge from a single process and keeps them stable through the next rising edge. It moves through lock, free-running, comma-framed and comma-ignored phases with both loopback and line input. Commas are placed at every bit offset of the line stream, so the framing logic meets each possible misalignment.

// File: rtl/serdes_pkg.sv
package serdes_pkg;

    // Default code group width and the width of the framing pattern.
    localparam int DEF_WORD_W = 10;
    localparam int COMMA_W    = 7;

    // Positive-disparity comma as a value: bit 0 is received first,
    // so the bit order 0,0,1,1,1,1,1 reads 7'b1111100.
    localparam logic [COMMA_W-1:0] DEF_COMMA = 7'b1111100;

    // Match either polarity of the framing pattern.
    function automatic logic comma_match(
        input logic [COMMA_W-1:0] win,
        input logic [COMMA_W-1:0] pat
    );
        return (win == pat) || (win == ~pat);
    endfunction

endpackage

// File: rtl/serdes_tx_shift.sv
module serdes_tx_shift #(
    parameter int WORD_W = serdes_pkg::DEF_WORD_W,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_take,
    output logic              tx_serial,
    output logic [CNT_W-1:0]  tx_phase
);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } tx_st_t;

    tx_st_t st_d, st_q;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    always_comb begin
        st_d = st_q;
        // Load in phase zero, otherwise move the next bit down to bit 0.
        if (st_q.cnt == '0) begin
            st_d.sh = tx_word;
        end else begin
            st_d.sh = st_q.sh >> 1;
        end
        st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_take   = (st_q.cnt == '0);
    assign tx_serial = st_q.sh[0];
    assign tx_phase  = st_q.cnt;

endmodule

// File: rtl/serdes_rx_align.sv
module serdes_rx_align #(
    parameter int WORD_W = serdes_pkg::DEF_WORD_W,
    parameter logic [serdes_pkg::COMMA_W-1:0] COMMA_PAT = serdes_pkg::DEF_COMMA,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              align_en,
    input  logic              lock_n,
    input  logic [CNT_W-1:0]  tx_phase,
    output logic              cap,
    output logic              cap_sync,
    output logic [WORD_W-1:0] cap_word,
    output logic [CNT_W-1:0]  bits_since
);

    localparam int CW = serdes_pkg::COMMA_W;
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(WORD_W);
    // Phase one cycle after the transmit load edge: a loopback word is complete.
    localparam logic [CNT_W-1:0] REF_SLOT = CNT_W'(1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   hit;
    logic   full;

    always_comb begin
        hit  = align_en && lock_n &&
               serdes_pkg::comma_match(st_q.sh[CW-1:0], COMMA_PAT);
        full = (st_q.cnt == FULL);
        cap  = lock_n ? (full || hit) : (tx_phase == REF_SLOT);

        st_d    = st_q;
        // Newest bit enters at the top, so the earliest bit ends at bit 0.
        st_d.sh = {bit_in, st_q.sh[WORD_W-1:1]};
        if (cap) begin
            st_d.cnt = CNT_W'(1);
        end else if (full) begin
            st_d.cnt = st_q.cnt;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_sync   = hit;
    assign cap_word   = st_q.sh;
    assign bits_since = st_q.cnt;

endmodule

// File: rtl/serdes_byteclk_out.sv
module serdes_byteclk_out #(
    parameter int WORD_W = serdes_pkg::DEF_WORD_W,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              cap_sync,
    input  logic [WORD_W-1:0] cap_word,
    input  logic [CNT_W-1:0]  bits_since,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_sync,
    output logic              byte_clk_a,
    output logic              byte_clk_b
);

    localparam logic [CNT_W-1:0] MID = CNT_W'(WORD_W / 2);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              sync;
        logic              phase;
        logic              clk_a;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap) begin
            st_d.word  = cap_word;
            st_d.sync  = cap_sync;
            st_d.phase = ~st_q.phase;
        end else if (bits_since == MID) begin
            // Edge placed mid-hold: the word is stable around it.
            st_d.clk_a = st_q.phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_word    = st_q.word;
    assign rx_sync    = st_q.sync;
    assign byte_clk_a = st_q.clk_a;
    assign byte_clk_b = ~st_q.clk_a;

endmodule

// File: rtl/serdes_rx_core.sv
module serdes_rx_core #(
    parameter int WORD_W = serdes_pkg::DEF_WORD_W,
    parameter logic [serdes_pkg::COMMA_W-1:0] COMMA_PAT = serdes_pkg::DEF_COMMA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_take,
    output logic              tx_serial,
    input  logic              rx_serial,
    input  logic              loop_en,
    input  logic              align_en,
    input  logic              lock_n,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_sync,
    output logic              byte_clk_a,
    output logic              byte_clk_b
);

    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [CNT_W-1:0]  tx_phase;
    logic              bit_in;
    logic              cap;
    logic              cap_sync;
    logic [WORD_W-1:0] cap_word;
    logic [CNT_W-1:0]  bits_since;

    serdes_tx_shift #(.WORD_W(WORD_W)) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_word   (tx_word),
        .tx_take   (tx_take),
        .tx_serial (tx_serial),
        .tx_phase  (tx_phase)
    );

    // Loopback selector in front of the receive shifter.
    assign bit_in = loop_en ? tx_serial : rx_serial;

    serdes_rx_align #(.WORD_W(WORD_W), .COMMA_PAT(COMMA_PAT)) i_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (bit_in),
        .align_en   (align_en),
        .lock_n     (lock_n),
        .tx_phase   (tx_phase),
        .cap        (cap),
        .cap_sync   (cap_sync),
        .cap_word   (cap_word),
        .bits_since (bits_since)
    );

    serdes_byteclk_out #(.WORD_W(WORD_W)) i_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap        (cap),
        .cap_sync   (cap_sync),
        .cap_word   (cap_word),
        .bits_since (bits_since),
        .rx_word    (rx_word),
        .rx_sync    (rx_sync),
        .byte_clk_a (byte_clk_a),
        .byte_clk_b (byte_clk_b)
    );

endmodule

// File: rtl/serdes_rx_core_chk.sv
module serdes_rx_core_chk #(
    parameter int WORD_W = serdes_pkg::DEF_WORD_W,
    parameter logic [serdes_pkg::COMMA_W-1:0] COMMA_PAT = serdes_pkg::DEF_COMMA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_take,
    input logic              align_en,
    input logic              lock_n,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_sync,
    input logic              byte_clk_a,
    input logic              byte_clk_b
);

    localparam int CW = serdes_pkg::COMMA_W;

    // R1: a load slot is never followed directly by another.
    p_take_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> !tx_take);

    // R5: a flagged group carries a comma in its low bits.
    p_sync_comma_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sync |-> serdes_pkg::comma_match(rx_word[CW-1:0], COMMA_PAT));

    // R6: a new flag appears only if framing was enabled at the capture edge.
    p_sync_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_sync) |-> $past(align_en));

    // R7: no flag can start while the boundary is tied to the reference.
    p_sync_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_sync) |-> $past(lock_n));

    // R8: the two byte clocks stay complementary.
    p_clk_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_clk_a != byte_clk_b);

    // R8: a byte clock never moves at the same edge as the held group.
    p_clk_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_clk_a) |-> $stable(rx_word));

endmodule

bind serdes_rx_core serdes_rx_core_chk #(.WORD_W(WORD_W), .COMMA_PAT(COMMA_PAT)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_take    (tx_take),
    .align_en   (align_en),
    .lock_n     (lock_n),
    .rx_word    (rx_word),
    .rx_sync    (rx_sync),
    .byte_clk_a (byte_clk_a),
    .byte_clk_b (byte_clk_b)
);

// File: tb/test_serdes_rx_core.sv
module test_serdes_rx_core;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] tx_word;
    logic       tx_take;
    logic       tx_serial;
    logic       rx_serial;
    logic       loop_en;
    logic       align_en;
    logic       lock_n;
    logic [9:0] rx_word;
    logic       rx_sync;
    logic       byte_clk_a;
    logic       byte_clk_b;

    always #4 clk = ~clk;

    serdes_rx_core i_serdes_rx_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_word    (tx_word),
        .tx_take    (tx_take),
        .tx_serial  (tx_serial),
        .rx_serial  (rx_serial),
        .loop_en    (loop_en),
        .align_en   (align_en),
        .lock_n     (lock_n),
        .rx_word    (rx_word),
        .rx_sync    (rx_sync),
        .byte_clk_a (byte_clk_a),
        .byte_clk_b (byte_clk_b)
    );

    // Behavioural reference state.
    int         m_tcnt, m_tidx, m_rcnt, m_ngroups;
    logic [9:0] m_tword, m_win, m_word;
    logic       m_sync, m_a;
    bit         m_hit, m_cap, m_bit;

    int         n_vec  = 0;
    int         n_fail = 0;
    int         n_comma_seen = 0;
    bit         done = 1'b0;
    string      tag = "R9";
    bit         cq[$];   // line bits still to send
    logic [9:0] wq[$];   // transmit words still to send

    localparam logic [9:0] CPOS = 10'h17C;  // low bits 1111100
    localparam logic [9:0] CNEG = 10'h283;  // low bits 0000011

    function automatic bit is_comma(logic [9:0] w);
        return (w[6:0] == 7'b1111100) || (w[6:0] == 7'b0000011);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tcnt = 0; m_tidx = 0; m_tword = '0;
            m_rcnt = 0; m_win = '0; m_word = '0;
            m_sync = 1'b0; m_a = 1'b0; m_ngroups = 0;
        end else begin
            m_bit = loop_en ? m_tword[m_tidx] : rx_serial;
            m_hit = align_en && lock_n && is_comma(m_win);
            m_cap = lock_n ? (m_rcnt == 10 || m_hit) : (m_tcnt == 1);
            if (m_cap) begin
                m_word = m_win;
                m_sync = m_hit;
                m_ngroups++;
            end else if (m_rcnt == 5) begin
                m_a = m_ngroups[0];
            end
            m_rcnt = m_cap ? 1 : (m_rcnt < 10 ? m_rcnt + 1 : 10);
            m_win  = {m_bit, m_win[9:1]};
            if (m_tcnt == 0) begin
                m_tword = tx_word;
                m_tidx  = 0;
            end else begin
                m_tidx++;
            end
            m_tcnt = (m_tcnt + 1) % 10;
        end
    end

    task automatic chk(string req, string sig, logic [9:0] act, logic [9:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h at %0t", req, sig, act, exp, $time);
        end
    endtask

    // Compare everything at the falling edge, then drive the next inputs.
    task automatic step();
        @(negedge clk);
        chk("R1", "tx_serial", 10'(tx_serial), 10'(m_tword[m_tidx]));
        chk("R1", "tx_take", 10'(tx_take), 10'(m_tcnt == 0));
        chk(tag, "rx_word", rx_word, m_word);
        chk("R5", "rx_sync", 10'(rx_sync), 10'(m_sync));
        chk("R8", "byte_clk_a", 10'(byte_clk_a), 10'(m_a));
        chk("R8", "byte_clk_b", 10'(byte_clk_b), 10'(!m_a));
        if (rx_sync) begin
            chk("R4", "comma group intact", 10'(is_comma(rx_word)), 10'd1);
            n_comma_seen++;
        end
        if (m_tcnt == 0) begin
            tx_word = (wq.size() > 0) ? wq.pop_front() : 10'($urandom);
        end
        rx_serial = (cq.size() > 0) ? cq.pop_front() : 1'($urandom);
    endtask

    task automatic push_word_bits(logic [9:0] w);
        for (int i = 0; i < 10; i++) cq.push_back(w[i]);
    endtask

    task automatic load_tx(int n, int comma_every);
        for (int i = 0; i < n; i++) begin
            if (comma_every > 0 && (i % comma_every) == comma_every - 1)
                wq.push_back((i % 2) ? CPOS : CNEG);
            else
                wq.push_back(10'($urandom));
        end
    endtask

    task automatic line_offsets();
        for (int off = 0; off < 10; off++) begin
            for (int k = 0; k < off + 3; k++) cq.push_back(1'($urandom));
            push_word_bits(10'($urandom));
            push_word_bits((off % 2) ? CPOS : CNEG);
            for (int k = 0; k < 4; k++) push_word_bits(10'($urandom));
            while (cq.size() > 0) step();
        end
    endtask

    initial begin
        int seen_before;
        rst_n = 1'b0; tx_word = '0; rx_serial = 1'b0;
        loop_en = 1'b1; align_en = 1'b1; lock_n = 1'b0;
        // R9: reset values.
        tag = "R9";
        for (int i = 0; i < 4; i++) step();
        rst_n = 1'b1;

        // R2 R7: loopback locked to transmit phase, commas ignored.
        tag = "R2 R7";
        load_tx(12, 3);
        for (int i = 0; i < 130; i++) step();

        // R6: framing off, free-running count; no flag may appear.
        tag = "R6 R3";
        lock_n = 1'b1; align_en = 1'b0;
        load_tx(10, 2);
        seen_before = n_comma_seen;
        for (int i = 0; i < 120; i++) step();
        chk("R6", "flags while framing off", 10'(n_comma_seen - seen_before), 10'd0);

        // R2 R4: line input with commas at every bit offset.
        tag = "R2 R4";
        loop_en = 1'b0; align_en = 1'b1;
        seen_before = n_comma_seen;
        line_offsets();
        chk("R4", "line commas framed", 10'(n_comma_seen > seen_before), 10'd1);

        // R6: same pattern on the line with framing off.
        tag = "R6";
        align_en = 1'b0;
        line_offsets();

        // R4 R5: loopback with framing on, commas inside random data.
        tag = "R4 R5";
        loop_en = 1'b1; align_en = 1'b1;
        seen_before = n_comma_seen;
        load_tx(30, 4);
        for (int i = 0; i < 320; i++) step();
        chk("R5", "loopback commas flagged", 10'(n_comma_seen > seen_before), 10'd1);

        // R7: re-lock after free running, count saturation and release.
        tag = "R7";
        lock_n = 1'b0;
        for (int i = 0; i < 37; i++) step();
        lock_n = 1'b1;
        for (int i = 0; i < 40; i++) step();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule